// File: doc/BRIEF.md
# Keyboard Character Latch with Ready Flag

This block takes a 7-bit character code from a parallel keyboard and holds it for a processor. The keyboard places a code on its data lines and raises a strobe. The block brings the strobe and the data into the clock domain through a two-flop synchronizer. On the synchronized low-to-high transition it stores the code and raises a "key ready" flag.

The processor reaches the block through a small synchronous bus port. A read of the data address returns the ready flag in bit 7 and the stored code in bits 6:0, one cycle after the access. Any access to the clear address drops the flag, whether it is a read or a write, and the stored code is kept. The flag then stays low until the next strobe edge. If a new key is captured in the same cycle as a clear access, the new key wins.

The strobe edge detector is a two-state machine. In state `ST_LOW` it waits for the synchronized strobe to be high. The transition `ST_LOW -> ST_HIGH` fires a single capture pulse. It stays in `ST_HIGH` while the strobe is held high. The transition `ST_HIGH -> ST_LOW` happens when the strobe falls and re-arms the detector. Reset enters `ST_LOW`.

Top module: `kbd_strobe_latch`

## Requirements
- R1: After reset the ready flag is 0 and the stored code is 0, so a read of the data address (0xC000, `bus_rw`=1 meaning read) returns 0x00.
- R2: A low-to-high transition of `kb_strobe` stores `kb_code` and sets the flag. The new value is visible to a read issued after the third rising clock edge following the strobe rise. Reads sampled at the first three edges still return the previous contents.
- R3: A strobe held high produces exactly one capture. Changes of `kb_code` while the strobe stays high do not alter the stored code. A flag cleared during that time stays clear.
- R4: A read access (`bus_en`=1, `bus_rw`=1) to the data address 0xC000 puts {flag, code} on `bus_rdata` in the next cycle: flag in bit 7, code in bits 6:0. The read itself does not change the flag.
- R5: Any access (`bus_en`=1, read or write) to the clear address 0xC010 clears the flag at that clock edge and keeps the stored code.
- R6: When a capture and a clear access fall on the same clock edge, the flag stays set and the new code is stored.
- R7: In a cycle following any clock edge with no read of the data address, `bus_rdata` is 0x00. This covers reads of the clear address and writes.
- R8: A write (`bus_rw`=0) to the data address 0xC000 changes neither the flag nor the stored code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access enable for this cycle |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Bus address |
| bus_rdata | output | 8 | Read data, registered; {flag, code} or zero |
| kb_code | input | 7 | Character code from the keyboard |
| kb_strobe | input | 1 | Keyboard strobe; rising edge means a new key |

## Verification
If the edge detector is stuck in the wrong state, the error shows as a missing capture or a repeated capture. It appears on the first data-address read after the strobe edge, within four cycles of that edge. If the flag register ignores the clear or clears on the wrong priority, the fault shows on the first read after a clear access, including the same-edge capture case. The bench follows every capture, clear and write with reads. It also reads cycle by cycle around a strobe edge, so a wrong synchronizer depth shifts the expected sequence by a whole cycle and cannot go unseen.

// File: rtl/kbd_latch_pkg.sv
package kbd_latch_pkg;

    // Edge-detector states for the synchronized keyboard strobe
    typedef enum logic {
        ST_LOW  = 1'b0,   // strobe low, armed for the next rising edge
        ST_HIGH = 1'b1    // strobe high, capture already taken
    } strobe_state_t;

    localparam logic BUS_READ  = 1'b1;
    localparam logic BUS_WRITE = 1'b0;

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/kbd_edge_fsm.sv
module kbd_edge_fsm
    import kbd_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    output logic capture
);

    strobe_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    // Next state and capture pulse
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_LOW: begin
                if (strobe_s) begin
                    state_d = ST_HIGH;
                    capture = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!strobe_s) state_d = ST_LOW;
            end
            default: state_d = ST_LOW;
        endcase
    end

    AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture); // R3

    AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (strobe_s && !$past(strobe_s))); // R2

endmodule

// File: rtl/kbd_key_reg.sv
module kbd_key_reg #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    input  logic              clear_req,
    output logic              ready,
    output logic [CODE_W-1:0] code
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            code  <= '0;
        end else begin
            if (capture) begin
                code  <= code_in;
                ready <= 1'b1;           // new key wins over a clear
            end else if (clear_req) begin
                ready <= 1'b0;
            end
        end
    end

    AST_CAPTURE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ready); // R2

    AST_CLEAR_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !capture) |=> !ready); // R5

    AST_CAPTURE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && capture) |=> (ready && code == $past(code_in))); // R6

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(code)); // R3

    AST_READY_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(capture)); // R8

endmodule

// File: rtl/kbd_bus_port.sv
module kbd_bus_port
    import kbd_latch_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                CODE_W     = 7,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'hC000,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR = 16'hC010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ready,
    input  logic [CODE_W-1:0] code,
    output logic              clear_req,
    output logic [CODE_W:0]   rdata
);

    logic data_read;

    assign data_read = bus_en && (bus_rw == BUS_READ) && (bus_addr == DATA_ADDR);
    assign clear_req = bus_en && (bus_addr == CLEAR_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n)         rdata <= '0;
        else if (data_read) rdata <= {ready, code};
        else                rdata <= '0;
    end

endmodule

// File: rtl/kbd_strobe_latch.sv
module kbd_strobe_latch #(
    parameter int                ADDR_W      = 16,
    parameter int                CODE_W      = 7,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hC000,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 16'hC010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [CODE_W:0]   bus_rdata,
    input  logic [CODE_W-1:0] kb_code,
    input  logic              kb_strobe
);

    localparam int SYNC_W = CODE_W + 1;

    logic [SYNC_W-1:0] kb_sync;
    logic              strobe_s;
    logic [CODE_W-1:0] code_s;
    logic              capture;
    logic              clear_req;
    logic              ready;
    logic [CODE_W-1:0] code;

    kbd_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({kb_strobe, kb_code}),
        .sync_out (kb_sync)
    );

    assign strobe_s = kb_sync[SYNC_W-1];
    assign code_s   = kb_sync[CODE_W-1:0];

    kbd_edge_fsm u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (strobe_s),
        .capture  (capture)
    );

    kbd_key_reg #(
        .CODE_W (CODE_W)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .code_in   (code_s),
        .clear_req (clear_req),
        .ready     (ready),
        .code      (code)
    );

    kbd_bus_port #(
        .ADDR_W     (ADDR_W),
        .CODE_W     (CODE_W),
        .DATA_ADDR  (DATA_ADDR),
        .CLEAR_ADDR (CLEAR_ADDR)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_rw    (bus_rw),
        .bus_addr  (bus_addr),
        .ready     (ready),
        .code      (code),
        .clear_req (clear_req),
        .rdata     (bus_rdata)
    );

    AST_READ_RETURNS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_rw && bus_addr == DATA_ADDR) |=>
            (bus_rdata == {$past(ready), $past(code)})); // R4

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_rw && bus_addr == DATA_ADDR) |=> (bus_rdata == '0)); // R7

    AST_READ_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_addr == DATA_ADDR && !capture) |=> $stable(ready)); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $rose(rst_n) |-> (!ready && code == '0)); // R1

endmodule

// File: tb/kbd_strobe_latch_tb.sv
module kbd_strobe_latch_tb;

    localparam time CLK_HALF = 10ns;   // 50 MHz
    localparam logic [15:0] A_DATA  = 16'hC000;
    localparam logic [15:0] A_CLEAR = 16'hC010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_rw = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_rdata;
    logic [6:0]  kb_code = '0;
    logic        kb_strobe = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    // bench model of the stored state
    logic       m_ready = 1'b0;
    logic [6:0] m_code  = '0;

    always #CLK_HALF clk = ~clk;

    kbd_strobe_latch u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_rw    (bus_rw),
        .bus_addr  (bus_addr),
        .bus_rdata (bus_rdata),
        .kb_code   (kb_code),
        .kb_strobe (kb_strobe)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Monitor: every read access gets its result compared one cycle later
    initial begin
        forever begin
            logic was_read;
            @(posedge clk);
            was_read = bus_en && bus_rw;
            @(negedge clk);
            if (was_read) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard: actual 0x%02h expected none", bus_rdata);
                end else begin
                    check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    // Driver tasks: called just after a falling edge, return after the next one
    task automatic access(input logic [15:0] a, input logic rw, input logic [7:0] exp,
                          input string tag);
        bus_en = 1'b1; bus_rw = rw; bus_addr = a;
        if (rw) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        bus_en = 1'b0; bus_rw = 1'b0; bus_addr = '0;
    endtask

    task automatic read_data(input string tag);
        access(A_DATA, 1'b1, {m_ready, m_code}, tag);
    endtask

    task automatic clear_write(input string tag);
        access(A_CLEAR, 1'b0, 8'h00, tag);
        m_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input logic [6:0] c);
        kb_code = c;
        idle(1);
        kb_strobe = 1'b1;
        idle(5);
        kb_strobe = 1'b0;
        idle(3);
        m_ready = 1'b1;
        m_code  = c;
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: empty after reset
        read_data("R1 reset contents");
        idle(1);
        check(bus_rdata, 8'h00, "R7 idle after read");

        // R2 / R4: a key press, read twice (read does not clear)
        press(7'h41);
        read_data("R2 capture 0x41");
        read_data("R4 second read keeps flag");

        // R5: clear by write, code kept
        clear_write("R5 clear by write");
        read_data("R5 flag dropped, code kept");

        // R5 / R7: clear by read of the clear address returns zero
        press(7'h5A);
        access(A_CLEAR, 1'b1, 8'h00, "R7 read of clear address is zero");
        m_ready = 1'b0;
        read_data("R5 clear by read");

        // R8 / R7: write to data address is ignored, no read data
        press(7'h33);
        access(A_DATA, 1'b0, 8'h00, "unused");
        check(bus_rdata, 8'h00, "R7 write cycle gives zero rdata");
        read_data("R8 write to data address ignored");

        // R2: cycle-exact visibility after a strobe rise
        clear_write("R2 prep");
        kb_code = 7'h2C;
        idle(1);
        kb_strobe = 1'b1;               // rises after a falling edge
        idle(1);                        // first rising edge passed
        read_data("R2 edge2 old contents");
        read_data("R2 edge3 old contents");
        m_ready = 1'b1; m_code = 7'h2C;
        read_data("R2 visible after edge3");
        kb_strobe = 1'b0;
        idle(3);

        // R3: strobe held high, data changes, clear stays effective
        clear_write("R3 prep");
        kb_code = 7'h11;
        idle(1);
        kb_strobe = 1'b1;
        idle(5);
        m_ready = 1'b1; m_code = 7'h11;
        read_data("R3 single capture");
        kb_code = 7'h7F;
        idle(4);
        read_data("R3 code unchanged while held");
        clear_write("R3 clear while held");
        idle(4);
        read_data("R3 flag stays clear while held");
        kb_strobe = 1'b0;
        idle(3);

        // R6: capture and clear on the same edge
        kb_code = 7'h66;
        idle(1);
        kb_strobe = 1'b1;
        idle(2);                        // capture pulse lies before edge 3
        access(A_CLEAR, 1'b0, 8'h00, "unused");
        m_ready = 1'b1; m_code = 7'h66;
        read_data("R6 new key beats clear");
        kb_strobe = 1'b0;
        idle(3);

        // R2: a second press after release is captured again
        press(7'h01);
        read_data("R2 re-armed capture");

        idle(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule